// File: doc/BRIEF.md
# Trace Synchronization Period Counter

This block decides when a trace stream must emit a full synchronization point on a fixed period. Software programs a 12-bit period through a small 32-bit register interface. A down-counter counts that period. In cycle mode it counts clock cycles. In byte mode it counts only the cycles that carry an emitted trace byte. When the counter expires, the block raises a one-cycle request. A separate unit, outside this block, builds the synchronization packets.

Any synchronization reloads the counter with the programmed period, including a synchronization requested from outside. A period of zero stops the periodic source, but external requests still reload the counter. Non-zero periods must exceed the trace FIFO depth, so a value that is too small is raised to the smallest legal value and recorded in a sticky flag.

Two build options change the register:
- Low period bits can be left out. Those bits then read as zero and count as zero.
- The register can be fixed to the value 1024. Writes to it are then ignored.

Top module: `trc_sync_timer`

## Requirements
- R1: After reset, the period word reads 0x00000400, the status word reads 0 and `sync_req_o` is low.
- R2: Word address 0 holds the period in bits [11:0], and bits [31:12] read as zero. Word address 1 holds the sticky illegal-value flag in bit 0, and writing a 1 to bit 0 of address 1 clears it.
- R3: In cycle mode (`byte_mode_i`=0) with a non-zero period P, `sync_req_o` is a one-cycle pulse, and consecutive pulses start exactly P cycles apart.
- R4: In byte mode (`byte_mode_i`=1), only cycles with `byte_vld_i`=1 advance the counter. With no bytes, no pulse is issued.
- R5: A period of zero issues no pulse on `sync_req_o`, whether or not external requests arrive.
- R6: `ext_sync_i` reloads the counter with the period on the next edge and does not pulse `sync_req_o`. A request that arrives on the edge where the counter expires gives a single reload.
- R7: A write that changes a non-zero period to another non-zero value does not restart the running count. The new value is first used at the next reload.
- R8: A write that changes the period from zero to a non-zero P loads the counter one cycle later. In cycle mode, the first pulse follows P+1 cycles after the write edge.
- R9: A write of a value from 1 to FIFO_DEPTH stores the smallest implemented value above FIFO_DEPTH (17 by default) and sets the sticky flag. The flag stays set through later legal writes.
- R10: With LSB_DROP=n, the low n period bits are stored, read and counted as zero. A written value that masks to 1..FIFO_DEPTH is clamped to the next multiple of 2^n.
- R11: With READ_ONLY=1, writes are ignored, the period word always reads 0x00000400, the flag is never set, and pulses come every 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word address: 0 = period, 1 = status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| byte_mode_i | input | 1 | 1 = count trace bytes, 0 = count cycles |
| byte_vld_i | input | 1 | A trace byte is emitted this cycle |
| ext_sync_i | input | 1 | External synchronization request, reloads the counter |
| sync_req_o | output | 1 | One-cycle periodic synchronization request |

## Verification
The bound checker watches several rules on every cycle:
- Reserved read bits stay zero.
- Pulses are one cycle wide.
- A zero period keeps the output quiet.
- The counter holds in byte mode when no byte arrives.
- An external request reloads the period.
- The stored period is always zero or above the FIFO depth, with its dropped bits clear.
- The read-only build keeps its fixed value.

Other behaviour only shows across many cycles, so the bench scenarios cover it:
- exact pulse spacing in both modes;
- deferred and immediate write timing;
- a request that coincides with expiry;
- the sticky flag and its clear;
- read-back for each build option.

// File: rtl/trc_sync_pkg.sv
package trc_sync_pkg;
  localparam int unsigned REG_W       = 32;
  localparam logic        ADDR_PERIOD = 1'b0;
  localparam logic        ADDR_STATUS = 1'b1;
  localparam int unsigned FIXED_PERIOD = 1024;
endpackage

// File: rtl/trc_sync_regs.sv
module trc_sync_regs
  import trc_sync_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 12,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LSB_DROP   = 0,
  parameter bit          READ_ONLY  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic                reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                restart_o
);
  localparam int unsigned GRAN = 1 << LSB_DROP;
  localparam int unsigned CLAMP_INT = ((FIFO_DEPTH / GRAN) + 1) * GRAN;
  localparam logic [PERIOD_W-1:0] KEEP_MASK = {PERIOD_W{1'b1}} << LSB_DROP;
  localparam logic [PERIOD_W-1:0] CLAMP_VAL = PERIOD_W'(CLAMP_INT);
  localparam logic [PERIOD_W-1:0] RESET_VAL = PERIOD_W'(FIXED_PERIOD) & KEEP_MASK;

  logic [PERIOD_W-1:0] period_q;
  logic                flag_q;
  logic                restart_q;

  // inputs only partly consumed in some builds
  logic unused_in;
  assign unused_in = ^{reg_wdata_i, reg_wr_i, clk_i, rst_ni};

  if (READ_ONLY) begin : g_ro
    assign period_q  = RESET_VAL;
    assign flag_q    = 1'b0;
    assign restart_q = 1'b0;
  end else begin : g_rw
    logic [PERIOD_W-1:0] wr_val;
    logic [PERIOD_W-1:0] wr_eff;
    logic [REG_W-1:0]    wr_ext;
    logic                wr_low;
    logic                wr_per;
    logic                wr_clr;

    always_comb begin
      wr_val = reg_wdata_i[PERIOD_W-1:0] & KEEP_MASK;
      wr_ext = REG_W'(wr_val);
      wr_low = (wr_val != '0) && (wr_ext <= FIFO_DEPTH);
      wr_eff = wr_low ? CLAMP_VAL : wr_val;
      wr_per = reg_wr_i && (reg_addr_i == ADDR_PERIOD);
      wr_clr = reg_wr_i && (reg_addr_i == ADDR_STATUS) && reg_wdata_i[0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        period_q  <= RESET_VAL;
        flag_q    <= 1'b0;
        restart_q <= 1'b0;
      end else begin
        restart_q <= wr_per && (period_q == '0) && (wr_eff != '0);
        if (wr_per) period_q <= wr_eff;
        if (wr_per && wr_low) flag_q <= 1'b1;
        else if (wr_clr)      flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (reg_addr_i == ADDR_PERIOD) reg_rdata_o = REG_W'(period_q);
    else                           reg_rdata_o = REG_W'(flag_q);
  end

  assign period_o  = period_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/trc_sync_cnt.sv
module trc_sync_cnt #(
  parameter int unsigned PERIOD_W = 12,
  parameter logic [PERIOD_W-1:0] RESET_CNT = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  input  logic                byte_mode_i,
  input  logic                byte_vld_i,
  input  logic                ext_sync_i,
  output logic [PERIOD_W-1:0] cnt_o,
  output logic                sync_req_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                sync_q;
  logic                tick;
  logic                active;
  logic                expire;

  always_comb begin
    tick   = byte_mode_i ? byte_vld_i : 1'b1;
    active = (period_i != '0);
    expire = active && tick && (cnt_q == PERIOD_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RESET_CNT;
      sync_q <= 1'b0;
    end else begin
      sync_q <= expire;
      // expiry, external request and restart share one reload
      if (expire || ext_sync_i || restart_i) cnt_q <= period_i;
      else if (tick && active && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign sync_req_o = sync_q;
endmodule

// File: rtl/trc_sync_timer.sv
module trc_sync_timer
  import trc_sync_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 12,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LSB_DROP   = 0,
  parameter bit          READ_ONLY  = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        byte_mode_i,
  input  logic        byte_vld_i,
  input  logic        ext_sync_i,
  output logic        sync_req_o
);
  localparam logic [PERIOD_W-1:0] KEEP_MASK = {PERIOD_W{1'b1}} << LSB_DROP;
  localparam logic [PERIOD_W-1:0] RESET_CNT = PERIOD_W'(FIXED_PERIOD) & KEEP_MASK;

  logic [PERIOD_W-1:0] period_w;
  logic [PERIOD_W-1:0] cnt_w;
  logic                restart_w;

  trc_sync_regs #(
    .PERIOD_W  (PERIOD_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .LSB_DROP  (LSB_DROP),
    .READ_ONLY (READ_ONLY)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .period_o   (period_w),
    .restart_o  (restart_w)
  );

  trc_sync_cnt #(
    .PERIOD_W (PERIOD_W),
    .RESET_CNT(RESET_CNT)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .period_i   (period_w),
    .restart_i  (restart_w),
    .byte_mode_i(byte_mode_i),
    .byte_vld_i (byte_vld_i),
    .ext_sync_i (ext_sync_i),
    .cnt_o      (cnt_w),
    .sync_req_o (sync_req_o)
  );
endmodule

// File: rtl/trc_sync_chk.sv
module trc_sync_chk
  import trc_sync_pkg::*;
#(
  parameter int unsigned PERIOD_W   = 12,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LSB_DROP   = 0,
  parameter bit          READ_ONLY  = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_addr_i,
  input logic [31:0]         reg_rdata_o,
  input logic                byte_mode_i,
  input logic                byte_vld_i,
  input logic                ext_sync_i,
  input logic                sync_req_o,
  input logic [PERIOD_W-1:0] period_i,
  input logic [PERIOD_W-1:0] cnt_i,
  input logic                restart_i
);
  localparam logic [PERIOD_W-1:0] LOW_MASK = ~({PERIOD_W{1'b1}} << LSB_DROP);

  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_PERIOD) |-> (reg_rdata_o[31:PERIOD_W] == '0));

  p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_o |=> !sync_req_o);

  p_byte_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_mode_i && !byte_vld_i && !ext_sync_i && !restart_i) |=> ($stable(cnt_i) && !sync_req_o));

  p_zero_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |=> !sync_req_o);

  p_ext_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sync_i |=> (cnt_i == $past(period_i)));

  p_period_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) || (32'(period_i) > FIFO_DEPTH));

  p_low_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i & LOW_MASK) == '0);

  if (READ_ONLY) begin : g_ro_chk
    p_ro_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(period_i) == FIXED_PERIOD);
  end
endmodule

bind trc_sync_timer trc_sync_chk #(
  .PERIOD_W  (PERIOD_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .LSB_DROP  (LSB_DROP),
  .READ_ONLY (READ_ONLY)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .byte_mode_i(byte_mode_i),
  .byte_vld_i (byte_vld_i),
  .ext_sync_i (ext_sync_i),
  .sync_req_o (sync_req_o),
  .period_i   (period_w),
  .cnt_i      (cnt_w),
  .restart_i  (restart_w)
);

// File: tb/trc_sync_timer_tb_top.sv
module trc_sync_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {write data, expected period read, expected flag}
  localparam logic [64:0] VEC [NVEC] = '{
    {32'h0000_0400, 32'h0000_0400, 1'b0},
    {32'hFFFF_F123, 32'h0000_0123, 1'b0},
    {32'h0000_0010, 32'h0000_0011, 1'b1},
    {32'h0000_0001, 32'h0000_0011, 1'b1},
    {32'h0000_0011, 32'h0000_0011, 1'b0},
    {32'h0000_0000, 32'h0000_0000, 1'b0},
    {32'h0000_0FFF, 32'h0000_0FFF, 1'b0},
    {32'hABCD_E020, 32'h0000_0020, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_m = 1'b0, wr_r = 1'b0, wr_l = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_m, rdata_r, rdata_l;
  logic        byte_mode = 1'b0, byte_vld = 1'b0, byte_gen = 1'b0, ext_sync = 1'b0;
  logic        sync_m, sync_r, sync_l;
  int          n_chk = 0, n_fail = 0;
  int          since = 0, last_gap = 0, pulses = 0;
  int          ro_since = 0, ro_gap = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  trc_sync_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_m), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_m), .byte_mode_i(byte_mode), .byte_vld_i(byte_vld),
    .ext_sync_i(ext_sync), .sync_req_o(sync_m));

  trc_sync_timer #(.READ_ONLY(1'b1)) dut_ro (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_r), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_r), .byte_mode_i(1'b0), .byte_vld_i(1'b0),
    .ext_sync_i(1'b0), .sync_req_o(sync_r));

  trc_sync_timer #(.LSB_DROP(4)) dut_lsb (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_l), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_l), .byte_mode_i(1'b0), .byte_vld_i(1'b0),
    .ext_sync_i(1'b0), .sync_req_o(sync_l));

  always @(negedge clk) begin
    byte_vld <= byte_gen ? ~byte_vld : 1'b0;
    if (!rst_n) begin
      since <= 0; pulses <= 0; ro_since <= 0;
    end else begin
      if (sync_m) begin last_gap <= since; since <= 1; pulses <= pulses + 1; end
      else since <= since + 1;
      if (sync_r) begin ro_gap <= ro_since; ro_since <= 1; end
      else ro_since <= ro_since + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int which, input logic a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr_m = (which == 0); wr_r = (which == 1); wr_l = (which == 2);
    @(negedge clk);
    wr_m = 1'b0; wr_r = 1'b0; wr_l = 1'b0;
  endtask

  task automatic bus_rd(input int which, input logic a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = (which == 0) ? rdata_m : (which == 1) ? rdata_r : rdata_l;
  endtask

  task automatic wait_pulse();
    int n = 0;
    do begin @(negedge clk); n++; end while (!sync_m && n < 5000);
    #1;
  endtask

  task automatic wait_ro_pulse();
    int n = 0;
    do begin @(negedge clk); n++; end while (!sync_r && n < 5000);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int pc;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(0, 1'b0, rd); chk("R1 period reset", rd, 32'h400);
    bus_rd(0, 1'b1, rd); chk("R1 flag reset", rd, 32'h0);
    chk("R1 no pulse", 32'(sync_m), 32'h0);
    bus_rd(2, 1'b0, rd); chk("R10 lsb reset", rd, 32'h400);

    // R2 R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(0, 1'b1, 32'h1);
      bus_wr(0, 1'b0, VEC[i][64:33]);
      bus_rd(0, 1'b0, rd); chk($sformatf("R2/R9 period vec %0d", i), rd, VEC[i][32:1]);
      bus_rd(0, 1'b1, rd); chk($sformatf("R9 flag vec %0d", i), rd, 32'(VEC[i][0]));
    end

    // R8 restart from zero, R3 spacing and width
    bus_wr(0, 1'b0, 32'h0);
    repeat (5) @(negedge clk);
    bus_wr(0, 1'b0, 32'd32);
    n = 0;
    do begin @(negedge clk); n++; end while (!sync_m && n < 200);
    chk("R8 first pulse", 32'(n), 32'd33);
    wait_pulse(); chk("R3 gap a", 32'(last_gap), 32'd32);
    @(negedge clk); #1; chk("R3 width", 32'(sync_m), 32'h0);
    wait_pulse(); chk("R3 gap b", 32'(last_gap), 32'd32);

    // R7 deferred write
    repeat (10) @(negedge clk);
    bus_wr(0, 1'b0, 32'd48);
    wait_pulse(); chk("R7 old period", 32'(last_gap), 32'd32);
    wait_pulse(); chk("R7 new period", 32'(last_gap), 32'd48);

    // R6 external reload
    repeat (10) @(negedge clk);
    ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
    wait_pulse(); chk("R6 ext reload gap", 32'(last_gap), 32'd59);
    repeat (47) @(negedge clk);
    ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
    #1;
    chk("R6 coincident pulse", 32'(sync_m), 32'h1);
    chk("R6 coincident gap", 32'(last_gap), 32'd48);
    wait_pulse(); chk("R6 single reload", 32'(last_gap), 32'd48);

    // R4 byte mode
    byte_mode = 1'b1; byte_gen = 1'b1;
    bus_wr(0, 1'b0, 32'h0);
    repeat (4) @(negedge clk);
    bus_wr(0, 1'b0, 32'd20);
    wait_pulse(); wait_pulse();
    chk("R4 byte gap", 32'(last_gap), 32'd40);
    byte_gen = 1'b0;
    repeat (2) @(negedge clk); #1;
    pc = pulses;
    repeat (200) @(negedge clk); #1;
    chk("R4 no bytes no pulse", 32'(pulses - pc), 32'd0);
    byte_mode = 1'b0;

    // R5 zero disables, ext requests still arrive
    bus_wr(0, 1'b0, 32'h0);
    repeat (2) @(negedge clk); #1;
    pc = pulses;
    for (int k = 0; k < 5; k++) begin
      repeat (300) @(negedge clk);
      ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
    end
    #1;
    chk("R5 zero quiet", 32'(pulses - pc), 32'd0);

    // R9 sticky flag, R2 clear
    bus_wr(0, 1'b1, 32'h1);
    bus_wr(0, 1'b0, 32'd5);
    bus_wr(0, 1'b0, 32'd100);
    bus_rd(0, 1'b1, rd); chk("R9 sticky", rd, 32'h1);
    bus_rd(0, 1'b0, rd); chk("R9 legal after", rd, 32'd100);
    bus_wr(0, 1'b1, 32'h0);
    bus_rd(0, 1'b1, rd); chk("R2 write0 keeps", rd, 32'h1);
    bus_wr(0, 1'b1, 32'h1);
    bus_rd(0, 1'b1, rd); chk("R2 w1c clears", rd, 32'h0);

    // R11 read-only build
    bus_wr(1, 1'b0, 32'h123);
    bus_rd(1, 1'b0, rd); chk("R11 ro ignores", rd, 32'h400);
    bus_wr(1, 1'b0, 32'd3);
    bus_rd(1, 1'b1, rd); chk("R11 ro flag", rd, 32'h0);
    bus_rd(1, 1'b0, rd); chk("R11 ro value", rd, 32'h400);
    wait_ro_pulse(); wait_ro_pulse();
    chk("R11 ro gap", 32'(ro_gap), 32'd1024);

    // R10 truncated low bits
    bus_wr(2, 1'b0, 32'h123);
    bus_rd(2, 1'b0, rd); chk("R10 masked read", rd, 32'h120);
    bus_wr(2, 1'b1, 32'h1);
    bus_wr(2, 1'b0, 32'h15);
    bus_rd(2, 1'b0, rd); chk("R10 clamp granule", rd, 32'h20);
    bus_rd(2, 1'b1, rd); chk("R10 clamp flag", rd, 32'h1);

    summary();
    $finish;
  end
endmodule